// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects interrupt requests from seven sources, numbered 1 to 7, and tells the processor which one to service. Identifier 0 stands for "nothing to service". Software uses a small synchronous register port. Writing request bits makes sources pending. Software chooses one of two arbitration modes. It reads the winning identifier from the low bits of a control/status word, and it retires that interrupt by writing its identifier back into an acknowledge field. A single level-sensitive line, `irq_out`, signals the processor.

In ordered mode, the order of service comes from a priority list that software loads. The list is a row of 3-bit slots, each holding a source identifier. The slot at the least significant end wins first. A pending source that is absent from the list is never selected in this mode. In scan mode, the list plays no part and the lowest-numbered pending source wins. Only one interrupt is active at a time. There is no vectoring and no nesting.

Register reads are combinational from `addr`. Writes take effect at the rising clock edge where `wr_en` is high. The winner and `irq_out` are combinational from the registered state, so they reflect a write from the clock edge onward.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no source is pending, every slot of the priority list is 0, scan mode is selected, `irq_out` is low, and the control/status word (address 0) reads 0x100.
- R2: A write to address 2 makes source n pending for each bit n, with n from 1 to 7, set in `wr_data`. Several bits may be set in one write. Bit 0 of that write is ignored. Address 2 reads back the pending set in bits [7:1].
- R3: Pending sources are cleared only by acknowledge. Writing 0 to address 2, or writing any other register, leaves them pending.
- R4: A write to address 0 with bits [1:0] equal to 2 selects ordered mode, and with 1 selects scan mode. Values 0 and 3 leave the mode unchanged. The current mode reads back in bits [9:8] of address 0.
- R5: In ordered mode, the active source is the pending identifier held in the lowest-numbered slot of the priority list. Slot k occupies bits [3k+2:3k] of address 1. Slot 0 has the highest priority.
- R6: In ordered mode, a pending source that appears in no slot is never active. A slot holding 0 is empty.
- R7: In scan mode, the active source is the lowest-numbered pending source.
- R8: Bits [2:0] of address 0 read the active identifier, or 0 if there is none. Bits [7:3] read 0, so the low byte is nonzero exactly when an interrupt is active.
- R9: A write to address 0 whose bits [6:4] equal the nonzero active identifier clears that source's pending bit. An acknowledge naming any other source has no effect.
- R10: `irq_out` is high exactly when an active identifier exists. It stays high after an acknowledge as long as another eligible source remains pending.
- R11: Address 1 reads back the priority list in bits [20:0], with the upper bits zero. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
Several properties are checked on every clock:
- the reported winner is always a pending source;
- in scan mode, no lower-numbered source is pending beside the winner;
- a request write leaves every requested bit set;
- only an acknowledge ever clears pending bits, and then at most one;
- the mode register only ever holds one of the two legal codes.

Other behaviour depends on particular register contents, so only the bench's scenarios can show it. This covers the order taken from the loaded list, the exclusion of unlisted sources, acknowledge of a non-active identifier, and the reserved mode codes. The bench compares `irq_out` against its own model on every cycle and reads back each register after each step.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef enum logic [1:0] {
      MODE_SCAN  = 2'd1,
      MODE_ORDER = 2'd2
   } irq_mode_e;

   localparam logic [1:0] A_CTRL  = 2'd0;
   localparam logic [1:0] A_ORDER = 2'd1;
   localparam logic [1:0] A_REQ   = 2'd2;

   localparam int MODE_WR_LSB = 0;
   localparam int ACK_LSB     = 4;
   localparam int MODE_RD_LSB = 8;
endpackage

// File: rtl/prio_irq_order_sel.sv
module prio_irq_order_sel #(
   parameter int NUM_SRC = 7,
   parameter int ID_W    = 3,
   localparam int TBL_W  = NUM_SRC * ID_W
) (
   input  logic [TBL_W-1:0] order_tbl,
   input  logic [NUM_SRC:0] pend,
   output logic [ID_W-1:0]  win_id
);
   logic [NUM_SRC-1:0] slot_hit;
   logic [ID_W-1:0]    slot_id [NUM_SRC];

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
      assign slot_id[k] = order_tbl[k*ID_W +: ID_W];
      always_comb begin
         slot_hit[k] = 1'b0;
         if (slot_id[k] != '0 && int'(slot_id[k]) <= NUM_SRC)
            slot_hit[k] = pend[slot_id[k]];
      end
   end

   always_comb begin
      win_id = '0;
      for (int k = NUM_SRC - 1; k >= 0; k--)
         if (slot_hit[k]) win_id = slot_id[k];
   end
endmodule

// File: rtl/prio_irq_scan_sel.sv
module prio_irq_scan_sel #(
   parameter int NUM_SRC = 7,
   parameter int ID_W    = 3
) (
   input  logic [NUM_SRC:0] pend,
   output logic [ID_W-1:0]  win_id
);
   always_comb begin
      win_id = '0;
      for (int n = NUM_SRC; n >= 1; n--)
         if (pend[n]) win_id = ID_W'(n);
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 7,
   parameter int ID_W    = 3,
   parameter int DATA_W  = 32,
   localparam int TBL_W  = NUM_SRC * ID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_out
);
   if (ID_W < $clog2(NUM_SRC + 1)) begin : g_bad_idw
      $error("ID_W too narrow for NUM_SRC");
   end
   if (DATA_W < TBL_W || DATA_W < MODE_RD_LSB + 2 || DATA_W < NUM_SRC + 1) begin : g_bad_dw
      $error("DATA_W too narrow");
   end
   if (ACK_LSB < ID_W || ACK_LSB + ID_W > 8) begin : g_bad_ack
      $error("acknowledge field must sit in the low byte above the ID");
   end

   logic [NUM_SRC:0] pend_q;
   logic [TBL_W-1:0] tbl_q;
   irq_mode_e        mode_q;
   logic [ID_W-1:0]  id_order, id_scan, act_id;
   logic [ID_W-1:0]  ack_id;
   logic [NUM_SRC:0] req_bits, ack_mask;
   logic             ack_ok;

   prio_irq_order_sel #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_order (
      .order_tbl(tbl_q), .pend(pend_q), .win_id(id_order));

   prio_irq_scan_sel #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_scan (
      .pend(pend_q), .win_id(id_scan));

   assign act_id  = (mode_q == MODE_ORDER) ? id_order : id_scan;
   assign irq_out = (act_id != '0);

   assign req_bits = {wr_data[NUM_SRC:1], 1'b0};
   assign ack_id   = wr_data[ACK_LSB +: ID_W];
   assign ack_ok   = (ack_id != '0) && (ack_id == act_id);
   assign ack_mask = ack_ok ? ((NUM_SRC+1)'(1) << ack_id) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         tbl_q  <= '0;
         mode_q <= MODE_SCAN;
      end else if (wr_en) begin
         case (addr)
            A_CTRL: begin
               if (wr_data[MODE_WR_LSB +: 2] == 2'd1) mode_q <= MODE_SCAN;
               else if (wr_data[MODE_WR_LSB +: 2] == 2'd2) mode_q <= MODE_ORDER;
               pend_q <= pend_q & ~ack_mask;
            end
            A_ORDER: tbl_q  <= wr_data[TBL_W-1:0];
            A_REQ:   pend_q <= pend_q | req_bits;
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (addr)
         A_CTRL: begin
            rd_data[ID_W-1:0]              = act_id;
            rd_data[MODE_RD_LSB +: 2]      = mode_q;
         end
         A_ORDER: rd_data[TBL_W-1:0]       = tbl_q;
         A_REQ:   rd_data[NUM_SRC:0]       = pend_q;
         default: ;
      endcase
   end

   // scan-mode lower-source mask for the R7 check
   logic [NUM_SRC:0] below_act;
   assign below_act = ((NUM_SRC+1)'(1) << act_id) - (NUM_SRC+1)'(1);

   a_r5_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (act_id != '0) |-> pend_q[act_id]);

   a_r7_scan_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SCAN && act_id != '0) |-> ((pend_q & below_act) == '0));

   a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_REQ) |=> ((pend_q & $past(req_bits)) == $past(req_bits)));

   a_r3_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_CTRL) |=> (($past(pend_q) & ~pend_q) == '0));

   a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CTRL) |=> ($countones($past(pend_q) & ~pend_q) <= 1));

   a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SCAN) || (mode_q == MODE_ORDER));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_en = 0;
   logic [1:0]  addr = 0;
   logic [31:0] wr_data = 0;
   logic [31:0] rd_data;
   logic        irq_out;

   int errs = 0, checks = 0;
   bit live = 0;

   // reference model
   bit m_pend [8];
   int m_slot [7];
   int m_mode = 1;

   always #2 clk = ~clk;

   prio_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                        .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out));

   function automatic int m_active();
      if (m_mode == 2) begin
         foreach (m_slot[k]) if (m_slot[k] != 0 && m_pend[m_slot[k]]) return m_slot[k];
         return 0;
      end
      for (int n = 1; n <= 7; n++) if (m_pend[n]) return n;
      return 0;
   endfunction

   function automatic void m_write(int a, int d);
      if (a == 0) begin
         int ack = (d >> 4) & 7;
         if (ack != 0 && ack == m_active()) m_pend[ack] = 0;
         if ((d & 3) == 1) m_mode = 1;
         else if ((d & 3) == 2) m_mode = 2;
      end else if (a == 1) begin
         for (int k = 0; k < 7; k++) m_slot[k] = (d >> (3*k)) & 7;
      end else if (a == 2) begin
         for (int n = 1; n <= 7; n++) if ((d >> n) & 1) m_pend[n] = 1;
      end
   endfunction

   // R10: per-cycle comparison of the interrupt line
   always @(negedge clk) if (live) begin
      checks++;
      if (irq_out !== (m_active() != 0)) begin
         errs++;
         $display("FAIL R10 irq_out act=%0b exp=%0b", irq_out, m_active() != 0);
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1; addr = 2'(a); wr_data = 32'(d);
      @(posedge clk); #1;
      m_write(a, d);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input int a, input logic [31:0] exp, input string tag);
      addr = 2'(a); #1;
      checks++;
      if (rd_data !== exp) begin
         errs++;
         $display("FAIL %s addr%0d act=0x%0h exp=0x%0h", tag, a, rd_data, exp);
      end
   endtask

   initial begin : watchdog
      #400000;
      errs++; checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      live = 1;
      // R1 reset state
      rd(0, 32'h100, "R1"); rd(1, 0, "R1"); rd(2, 0, "R1");
      rd(3, 0, "R11");
      // R2 R7 scan mode with two sources
      wr(2, 32'h28);
      rd(2, 32'h28, "R2"); rd(0, 32'h103, "R7");
      // R3 zero write keeps pending
      wr(2, 0);
      rd(2, 32'h28, "R3");
      // R9 acknowledge of non-active source ignored
      wr(0, 32'h50);
      rd(2, 32'h28, "R9"); rd(0, 32'h103, "R9");
      // R9 R10 acknowledge active, next still raises irq
      wr(0, 32'h30);
      rd(0, 32'h105, "R10"); rd(2, 32'h20, "R9");
      // R2 bit 0 ignored
      wr(2, 32'h01);
      rd(2, 32'h20, "R2");
      // R11 list load: slot0=6 slot1=2 slot2=5
      wr(1, 32'h156);
      rd(1, 32'h156, "R11"); rd(0, 32'h105, "R7");
      // R4 ordered mode
      wr(0, 2);
      rd(0, 32'h205, "R4");
      // R5 multi-bit request
      wr(2, 32'h84);
      rd(0, 32'h202, "R5");
      wr(2, 32'h40);
      rd(0, 32'h206, "R5");
      wr(0, 32'h60); rd(0, 32'h202, "R5");
      wr(0, 32'h20); rd(0, 32'h205, "R5");
      // R6 unlisted source 7 stays pending but inactive; R8 low byte zero
      wr(0, 32'h50);
      rd(0, 32'h200, "R8"); rd(2, 32'h80, "R6");
      // R4 reserved code leaves mode
      wr(0, 3);
      rd(0, 32'h200, "R4");
      // R4 R7 back to scan mode
      wr(0, 1);
      rd(0, 32'h107, "R7");
      wr(0, 32'h70);
      rd(0, 32'h100, "R8"); rd(2, 0, "R9");
      repeat (4) @(negedge clk);
      live = 0;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule